// File: doc/BRIEF.md
# Single-Channel Byte DMA Engine

This block is one DMA channel that copies bytes from a source location to a destination location. Each side is placed in one of three address spaces: external data memory, the special-function-register space, or internal data RAM. Software loads a source address, a destination address, a byte count and an eight-bit control byte through a simple register write port. It then either starts the copy directly or arms the channel so that an external request pin or a serial-port flag paces it. Each byte is fetched through a byte-wide read port and stored through a byte-wide write port. Both ports use a request/ready handshake: a transfer completes on a clock edge where request and ready are both high.

In software-started mode the channel either holds the bus for the whole block (burst) or gives the bus back for one cycle after every byte so that an instruction cycle can run (alternate cycles). In demand mode the channel moves one byte for each rising edge on the selected request input. When the count runs out, the channel sets its done flag, which drives the interrupt output. The flag is cleared by an interrupt acknowledge or by a software write.

Top module: `dma_channel`

## Requirements
- R1: The control byte has these fields: bit 7 destination space, bit 6 destination step, bit 5 source space, bit 4 source step, bit 3 demand mode, bit 2 pacing/trigger select, bit 1 done, bit 0 go. `cfg_sel` codes are 0 for the source address, 1 for the destination address, 2 for the count and 3 for the control byte.
- R2: A side's space code on `rd_space`/`wr_space` is 0 (external memory) when its space bit is 0. It is 1 (special-function register) when the space bit is 1 and the step bit is 0. It is 2 (internal RAM) when both bits are 1.
- R3: A side whose step bit is 1 advances its address by one after each byte moved. A side whose step bit is 0 keeps its address fixed.
- R4: Each byte is one read handshake followed by one write handshake. The write carries the byte that was read, and the count drops by one per byte.
- R5: With demand mode 0 and pacing 1 (burst), `bus_req` stays high from the first read until the last write completes.
- R6: With demand mode 0 and pacing 0 (alternate cycles), `bus_req` is low for exactly one cycle after each byte except the last.
- R7: With demand mode 1 and go set, each rising edge of `dreq_ext` (pacing 1) or of `dreq_ser` (pacing 0) moves exactly one byte. The input that is not selected, and the absence of any edge, move nothing.
- R8: When the last byte's write completes, done is set, go is cleared and `irq` goes high.
- R9: A start with a count of zero sets done and clears go without any read or write, and leaves both addresses unchanged.
- R10: `irq_ack` clears done. A software write to the control byte sets or clears done directly.
- R11: While `active` is high, register writes have no effect.
- R12: After reset all registers read zero and `irq`, `bus_req` and `active` are low.
- R13: A pending read request holds its request and address until ready is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select (R1) |
| cfg_wdata | input | RW | Register write data |
| src_addr | output | AW | Source address register |
| dst_addr | output | AW | Destination address register |
| count | output | CW | Remaining byte count |
| ctrl | output | 8 | Control byte |
| dreq_ext | input | 1 | External demand request |
| dreq_ser | input | 1 | Serial-port demand flag |
| irq_ack | input | 1 | Interrupt acknowledge, clears done |
| rd_req | output | 1 | Read request |
| rd_space | output | 2 | Read address space code |
| rd_addr | output | AW | Read address |
| rd_data | input | DW | Read data, valid with rd_ready |
| rd_ready | input | 1 | Read ready |
| wr_req | output | 1 | Write request |
| wr_space | output | 2 | Write address space code |
| wr_addr | output | AW | Write address |
| wr_data | output | DW | Write data |
| wr_ready | input | 1 | Write ready |
| irq | output | 1 | Interrupt request, equal to done |
| bus_req | output | 1 | Channel holds the memory bus |
| active | output | 1 | A byte transfer is in progress |

## Verification
The properties assume that `rd_data` is valid in any cycle where `rd_ready` meets a pending read. They also assume that software does not pulse `irq_ack` while go is set, since go set means a completion can be pending. The bench keeps to this: its memory model computes read data from the space and address in the same cycle, and it issues acknowledges only after go has cleared. It spaces demand pulses further apart than one byte takes, so a single pending flag is always enough. Register writes during a transfer are made only in the case that checks they are ignored.

// File: rtl/dmach_pkg.sv
`timescale 1ns/1ps
package dmach_pkg;
  // control byte field positions (decoded by the channel itself)
  localparam int CB_DSP  = 7;
  localparam int CB_DINC = 6;
  localparam int CB_SSP  = 5;
  localparam int CB_SINC = 4;
  localparam int CB_DEM  = 3;
  localparam int CB_PACE = 2;
  localparam int CB_DONE = 1;
  localparam int CB_GO   = 0;

  typedef enum logic [1:0] {
    SP_XDATA = 2'd0,
    SP_SFR   = 2'd1,
    SP_IRAM  = 2'd2
  } space_t;

  typedef enum logic [1:0] {
    SEL_SRC  = 2'd0,
    SEL_DST  = 2'd1,
    SEL_CNT  = 2'd2,
    SEL_CTRL = 2'd3
  } regsel_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WR   = 2'd2,
    ST_GAP  = 2'd3
  } seq_t;
endpackage

// File: rtl/dmach_space.sv
`timescale 1ns/1ps
module dmach_space
  import dmach_pkg::*;
(
  input  logic   sp_bit,
  input  logic   step_bit,
  output space_t code
);
  always_comb begin
    if (!sp_bit)       code = SP_XDATA;
    else if (step_bit) code = SP_IRAM;
    else               code = SP_SFR;
  end
endmodule

// File: rtl/dmach_regs.sv
`timescale 1ns/1ps
module dmach_regs
  import dmach_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16,
  parameter int RW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [1:0]    sel,
  input  logic [RW-1:0] wdata,
  input  logic          busy,
  input  logic          step,
  input  logic          fin,
  input  logic          ack,
  output logic [AW-1:0] src_q,
  output logic [AW-1:0] dst_q,
  output logic [CW-1:0] cnt_q,
  output logic [7:0]    ctrl_q
);
  logic wr_ok;
  assign wr_ok = we && !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q  <= '0;
      dst_q  <= '0;
      cnt_q  <= '0;
      ctrl_q <= '0;
    end else if (wr_ok) begin
      case (regsel_t'(sel))
        SEL_SRC:  src_q  <= wdata[AW-1:0];
        SEL_DST:  dst_q  <= wdata[AW-1:0];
        SEL_CNT:  cnt_q  <= wdata[CW-1:0];
        default:  ctrl_q <= wdata[7:0];
      endcase
    end else begin
      if (step) begin
        if (ctrl_q[CB_SINC]) src_q <= src_q + 1'b1;
        if (ctrl_q[CB_DINC]) dst_q <= dst_q + 1'b1;
        cnt_q <= cnt_q - 1'b1;
      end
      if (fin) begin
        ctrl_q[CB_DONE] <= 1'b1;
        ctrl_q[CB_GO]   <= 1'b0;
      end else if (ack) begin
        ctrl_q[CB_DONE] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dmach_trig.sv
`timescale 1ns/1ps
module dmach_trig (
  input  logic clk,
  input  logic rst,
  input  logic ext_in,
  input  logic ser_in,
  input  logic use_ext,
  input  logic arm,
  input  logic take,
  output logic pend
);
  logic ext_d, ser_d, rise;

  assign rise = use_ext ? (ext_in && !ext_d) : (ser_in && !ser_d);

  always_ff @(posedge clk) begin
    if (rst) begin
      ext_d <= 1'b0;
      ser_d <= 1'b0;
      pend  <= 1'b0;
    end else begin
      ext_d <= ext_in;
      ser_d <= ser_in;
      if (!arm) pend <= 1'b0;
      else      pend <= rise || (pend && !take);
    end
  end
endmodule

// File: rtl/dmach_seq.sv
`timescale 1ns/1ps
module dmach_seq
  import dmach_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic          demand,
  input  logic          pace,
  input  logic          cnt_zero,
  input  logic          cnt_one,
  input  logic          pend,
  input  logic          rd_ready,
  input  logic [DW-1:0] rd_data,
  input  logic          wr_ready,
  output logic          rd_req,
  output logic          wr_req,
  output logic [DW-1:0] wr_data,
  output logic          step,
  output logic          fin,
  output logic          take,
  output logic          busy
);
  seq_t st;
  logic start;

  assign start = (st == ST_IDLE) && go && !cnt_zero && (!demand || pend);
  assign take  = start && demand;
  assign step  = (st == ST_WR) && wr_ready;
  assign fin   = ((st == ST_IDLE) && go && cnt_zero) || (step && cnt_one);
  assign busy  = (st != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      rd_req  <= 1'b0;
      wr_req  <= 1'b0;
      wr_data <= '0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (start) begin
            st     <= ST_RD;
            rd_req <= 1'b1;
          end
        end
        ST_RD: begin
          if (rd_ready) begin
            wr_data <= rd_data;
            rd_req  <= 1'b0;
            wr_req  <= 1'b1;
            st      <= ST_WR;
          end
        end
        ST_WR: begin
          if (wr_ready) begin
            wr_req <= 1'b0;
            if (cnt_one || demand) begin
              st <= ST_IDLE;
            end else if (!pace) begin
              st <= ST_GAP;
            end else begin
              st     <= ST_RD;
              rd_req <= 1'b1;
            end
          end
        end
        default: begin
          st     <= ST_RD;
          rd_req <= 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/dma_channel.sv
`timescale 1ns/1ps
module dma_channel
  import dmach_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16,
  parameter int DW = 8,
  parameter int RW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_sel,
  input  logic [RW-1:0] cfg_wdata,
  output logic [AW-1:0] src_addr,
  output logic [AW-1:0] dst_addr,
  output logic [CW-1:0] count,
  output logic [7:0]    ctrl,
  input  logic          dreq_ext,
  input  logic          dreq_ser,
  input  logic          irq_ack,
  output logic          rd_req,
  output logic [1:0]    rd_space,
  output logic [AW-1:0] rd_addr,
  input  logic [DW-1:0] rd_data,
  input  logic          rd_ready,
  output logic          wr_req,
  output logic [1:0]    wr_space,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  input  logic          wr_ready,
  output logic          irq,
  output logic          bus_req,
  output logic          active
);
  localparam int SIDES = 2;

  logic   step, fin, take, busy, pend;
  space_t sp_code [SIDES];

  dmach_regs #(.AW(AW), .CW(CW), .RW(RW)) u_regs (
    .clk(clk), .rst(rst), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
    .busy(busy), .step(step), .fin(fin), .ack(irq_ack),
    .src_q(src_addr), .dst_q(dst_addr), .cnt_q(count), .ctrl_q(ctrl)
  );

  // side 0 = source (bits 5/4), side 1 = destination (bits 7/6)
  for (genvar g = 0; g < SIDES; g++) begin : g_side
    dmach_space u_sp (
      .sp_bit  (ctrl[CB_SSP + 2*g]),
      .step_bit(ctrl[CB_SINC + 2*g]),
      .code    (sp_code[g])
    );
  end

  dmach_trig u_trig (
    .clk(clk), .rst(rst), .ext_in(dreq_ext), .ser_in(dreq_ser),
    .use_ext(ctrl[CB_PACE]), .arm(ctrl[CB_GO] && ctrl[CB_DEM]),
    .take(take), .pend(pend)
  );

  dmach_seq #(.DW(DW)) u_seq (
    .clk(clk), .rst(rst), .go(ctrl[CB_GO]), .demand(ctrl[CB_DEM]),
    .pace(ctrl[CB_PACE]), .cnt_zero(count == '0),
    .cnt_one(count == CW'(1)), .pend(pend),
    .rd_ready(rd_ready), .rd_data(rd_data), .wr_ready(wr_ready),
    .rd_req(rd_req), .wr_req(wr_req), .wr_data(wr_data),
    .step(step), .fin(fin), .take(take), .busy(busy)
  );

  assign rd_space = sp_code[0];
  assign wr_space = sp_code[1];
  assign rd_addr  = src_addr;
  assign wr_addr  = dst_addr;
  assign irq      = ctrl[CB_DONE];
  assign bus_req  = rd_req || wr_req;
  assign active   = busy;
endmodule

// File: rtl/dma_channel_chk.sv
`timescale 1ns/1ps
module dma_channel_chk #(
  parameter int AW = 16,
  parameter int CW = 16,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          cfg_we,
  input logic          irq_ack,
  input logic          rd_req,
  input logic          rd_ready,
  input logic [AW-1:0] rd_addr,
  input logic [DW-1:0] rd_data,
  input logic          wr_req,
  input logic          wr_ready,
  input logic [DW-1:0] wr_data,
  input logic [AW-1:0] src_addr,
  input logic [AW-1:0] dst_addr,
  input logic [CW-1:0] count,
  input logic [7:0]    ctrl,
  input logic          irq,
  input logic          bus_req
);
  logic wr_hs;
  assign wr_hs = wr_req && wr_ready;

  assert_read_hold_R13: assert property (@(posedge clk) disable iff (rst)
    rd_req && !rd_ready |=> rd_req && $stable(rd_addr));

  assert_write_follows_read_R4: assert property (@(posedge clk) disable iff (rst)
    rd_req && rd_ready |=> wr_req && (wr_data == $past(rd_data)));

  assert_count_step_R4: assert property (@(posedge clk) disable iff (rst)
    wr_hs |=> count == CW'($past(count) - 1'b1));

  assert_src_advance_R3: assert property (@(posedge clk) disable iff (rst)
    wr_hs && ctrl[4] |=> src_addr == AW'($past(src_addr) + 1'b1));

  assert_dst_fixed_R3: assert property (@(posedge clk) disable iff (rst)
    wr_hs && !ctrl[6] |=> $stable(dst_addr));

  assert_burst_hold_R5: assert property (@(posedge clk) disable iff (rst)
    wr_hs && !ctrl[3] && ctrl[2] && count != CW'(1) |=> rd_req);

  assert_alt_release_R6: assert property (@(posedge clk) disable iff (rst)
    wr_hs && !ctrl[3] && !ctrl[2] |=> !bus_req);

  assert_last_done_R8: assert property (@(posedge clk) disable iff (rst)
    wr_hs && count == CW'(1) |=> irq && !ctrl[0]);

  assert_ack_clears_R10: assert property (@(posedge clk) disable iff (rst)
    irq_ack && !cfg_we && !ctrl[0] |=> !irq);
endmodule

bind dma_channel dma_channel_chk #(.AW(AW), .CW(CW), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .cfg_we(cfg_we), .irq_ack(irq_ack),
  .rd_req(rd_req), .rd_ready(rd_ready), .rd_addr(rd_addr), .rd_data(rd_data),
  .wr_req(wr_req), .wr_ready(wr_ready), .wr_data(wr_data),
  .src_addr(src_addr), .dst_addr(dst_addr), .count(count), .ctrl(ctrl),
  .irq(irq), .bus_req(bus_req)
);

// File: tb/sim_dma_channel.sv
`timescale 1ns/1ps
module sim_dma_channel;
  localparam int AW = 16, CW = 16, DW = 8, RW = 16;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst, cfg_we, dreq_ext, dreq_ser, irq_ack;
  logic [1:0]    cfg_sel;
  logic [RW-1:0] cfg_wdata;
  logic [AW-1:0] src_addr, dst_addr, rd_addr, wr_addr;
  logic [CW-1:0] count;
  logic [7:0]    ctrl;
  logic          rd_req, wr_req, rd_ready, wr_ready, irq, bus_req, active;
  logic [1:0]    rd_space, wr_space;
  logic [DW-1:0] rd_data, wr_data;

  dma_channel #(.AW(AW), .CW(CW), .DW(DW), .RW(RW)) u0 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .src_addr(src_addr), .dst_addr(dst_addr), .count(count), .ctrl(ctrl),
    .dreq_ext(dreq_ext), .dreq_ser(dreq_ser), .irq_ack(irq_ack),
    .rd_req(rd_req), .rd_space(rd_space), .rd_addr(rd_addr), .rd_data(rd_data),
    .rd_ready(rd_ready), .wr_req(wr_req), .wr_space(wr_space), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_ready(wr_ready), .irq(irq), .bus_req(bus_req),
    .active(active)
  );

  function automatic logic [7:0] mem_val(input logic [1:0] sp, input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ (8'h47 * {6'd0, sp}) ^ 8'h3C;
  endfunction

  function automatic logic [1:0] space_of(input logic s, input logic i);
    return !s ? 2'd0 : (i ? 2'd2 : 2'd1);
  endfunction

  assign rd_data  = mem_val(rd_space, rd_addr);
  logic gate = 1'b1;
  assign rd_ready = gate;
  assign wr_ready = gate;

  int total = 0, bad = 0, tick = 0, rdy_mode = 0;
  int wcount = 0, werr = 0, gapcnt = 0;
  logic [15:0] e_src0, e_dst0;
  logic [1:0]  e_ssp, e_dsp;
  logic        e_sinc, e_dinc;

  always @(negedge clk) begin
    if (wr_req && wr_ready) begin
      if (wr_addr !== 16'(e_dst0 + (e_dinc ? wcount : 0)) || wr_space !== e_dsp ||
          wr_data !== mem_val(e_ssp, 16'(e_src0 + (e_sinc ? wcount : 0))))
        werr++;
      wcount++;
    end
    if (active && !bus_req) gapcnt++;
    tick++;
    case (rdy_mode)
      0:       gate = 1'b1;
      1:       gate = (tick % 3) != 0;
      default: gate = 1'b0;
    endcase
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [1:0] s, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wait_go_clear();
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      if (!ctrl[0] && !active) break;
    end
  endtask

  task automatic set_exp(input logic [15:0] s0, input logic [15:0] d0, input logic [3:0] sp);
    e_src0 = s0; e_dst0 = d0;
    e_dsp = space_of(sp[3], sp[2]); e_dinc = sp[2];
    e_ssp = space_of(sp[1], sp[0]); e_sinc = sp[0];
    wcount = 0; werr = 0; gapcnt = 0;
  endtask

  task automatic run_sw(input logic [3:0] sp, input logic tm, input int n,
                        input logic [15:0] s0, input logic [15:0] d0);
    set_exp(s0, d0, sp);
    reg_wr(2'd0, s0);
    reg_wr(2'd1, d0);
    reg_wr(2'd2, 16'(n));
    gapcnt = 0;
    reg_wr(2'd3, {8'd0, sp, 1'b0, tm, 2'b01});
    wait_go_clear();
    chk("R4 bytes written", wcount, n);
    chk("R2 R4 write data/space/address", werr, 0);
    chk("R3 source address", src_addr, 16'(s0 + (sp[0] ? n : 0)));
    chk("R3 destination address", dst_addr, 16'(d0 + (sp[2] ? n : 0)));
    chk("R8 count exhausted", count, 0);
    chk("R8 R9 control done/go", ctrl, {sp, 1'b0, tm, 2'b10});
    chk("R8 irq", irq, 1);
    if (tm) chk("R5 burst bus hold gaps", gapcnt, 0);
    else    chk("R6 alternate gaps", gapcnt, (n > 0) ? n - 1 : 0);
    @(negedge clk); irq_ack = 1'b1;
    @(negedge clk); irq_ack = 1'b0;
    chk("R10 ack clears irq", irq, 0);
  endtask

  task automatic pulse(input logic use_ext);
    @(negedge clk);
    if (use_ext) dreq_ext = 1'b1; else dreq_ser = 1'b1;
    repeat (2) @(negedge clk);
    dreq_ext = 1'b0; dreq_ser = 1'b0;
    repeat (10) @(negedge clk);
  endtask

  task automatic run_demand(input logic tm);
    rdy_mode = 0;
    set_exp(16'h30FE, 16'h0480, 4'b1101);
    reg_wr(2'd0, 16'h30FE);
    reg_wr(2'd1, 16'h0480);
    reg_wr(2'd2, 16'd3);
    reg_wr(2'd3, {8'd0, 4'b1101, 1'b1, tm, 2'b01});
    repeat (12) @(negedge clk);
    chk("R7 no edge moves nothing", wcount, 0);
    pulse(!tm);
    chk("R7 unselected input ignored", count, 3);
    pulse(tm);
    chk("R7 one byte per edge", wcount, 1);
    chk("R7 count after one edge", count, 2);
    pulse(tm);
    pulse(tm);
    chk("R7 three edges three bytes", wcount, 3);
    chk("R7 R4 demand data", werr, 0);
    chk("R8 demand done", ctrl, {4'b1101, 1'b1, tm, 2'b10});
    chk("R3 demand destination", dst_addr, 16'h0483);
    pulse(tm);
    chk("R7 no byte after done", wcount, 3);
  endtask

  initial begin
    #(20 * 150000);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst = 1'b1; cfg_we = 1'b0; cfg_sel = 2'd0; cfg_wdata = '0;
    dreq_ext = 1'b0; dreq_ser = 1'b0; irq_ack = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R12 reset src", src_addr, 0);
    chk("R12 reset dst", dst_addr, 0);
    chk("R12 reset count", count, 0);
    chk("R12 reset ctrl", ctrl, 0);
    chk("R12 reset outputs", {irq, bus_req, active}, 0);

    // software done control, R10
    reg_wr(2'd3, 16'h0002);
    chk("R10 software sets done", irq, 1);
    reg_wr(2'd3, 16'h0000);
    chk("R10 software clears done", irq, 0);

    // sweep of spaces, step bits, pacing and counts, R1 R2 R3 R5 R6 R8 R9
    for (int c = 0; c < 16; c++) begin
      for (int t = 0; t < 2; t++) begin
        for (int k = 0; k < 3; k++) begin
          rdy_mode = (c + k) % 2;
          run_sw(c[3:0], t[0], (k == 0) ? 0 : ((k == 1) ? 1 : 3),
                 16'(16'h10FE + c * 7), 16'(16'h22FF - c * 5));
        end
      end
    end

    // writes ignored during a transfer, R11
    rdy_mode = 2;
    set_exp(16'h0A00, 16'h0B00, 4'b0101);
    reg_wr(2'd0, 16'h0A00);
    reg_wr(2'd1, 16'h0B00);
    reg_wr(2'd2, 16'd4);
    reg_wr(2'd3, 16'h0055);
    repeat (4) @(negedge clk);
    chk("R11 transfer active", active, 1);
    reg_wr(2'd0, 16'hBEEF);
    reg_wr(2'd2, 16'd9);
    chk("R11 count unchanged by write", count, 4);
    chk("R13 request held while stalled", rd_req, 1);
    rdy_mode = 0;
    wait_go_clear();
    chk("R11 source ignores busy write", src_addr, 16'h0A04);
    chk("R11 bytes moved", wcount, 4);
    chk("R11 data intact", werr, 0);

    // demand mode on each trigger input, R7
    run_demand(1'b1);
    run_demand(1'b0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule